// File: doc/BRIEF.md
# Iterative Word-Shift Stream Hash Core

This block hashes a stream of W-bit message words into a digest of H/2 words. It keeps an internal state of H words, a feedback word and a full-width round count. A single small-round unit runs once per clock, so one full round takes eight clocks. Each message word is absorbed over one full round and held for all eight of its small rounds. When the word flagged as last has been absorbed, the core runs H blank rounds with zero input. It then runs H/2 further blank rounds and emits the feedback word after each one. The digest therefore appears one word every eight clocks.

The small-round unit never selects state words by index. It always reads fixed positions of the state. After each small round the whole state moves down by one word, and the word that was used last wraps to the top. This shift has the same effect as advancing the index. The round count fed into the mixing function is held in a separate counter, which the shift does not touch. Message padding is the job of the producer. The core takes words through a valid/ready pair and accepts a new word only at a full-round boundary. After the last digest word it returns to its initial state, ready for the next message.

Top module: `whash_core`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0. The state words and the feedback word are zero, and the round count is 1.
- R2: A word is taken on a clock edge where in_valid and in_ready are both 1. in_ready is then 0 for the next 7 cycles and returns to 1 in the 8th, so a non-last word occupies exactly eight clocks.
- R3: The digest is defined by an index-based model. A small round with input p computes f = rotr(2·x[r−1] ⊕ x[r+1] ⊕ d ⊕ r, W/4) · 9, with all arithmetic modulo 2^W and indices modulo H. It then sets x[r] ^= f, sets d ^= f ⊕ p ⊕ x[H/2 + r] (using the updated state), and increments r. Each message word drives eight small rounds. These are followed by H full rounds with p = 0, then H/2 full rounds with p = 0, and d after each of these last rounds is one digest word, in order. Each out_word equals the corresponding model word.
- R4: Let the last word be taken at edge E0. Digest word k (k = 0..H/2−1) is presented with out_valid = 1 for exactly one cycle, after edge 143 + 8k. out_last is 1 only with word H/2−1.
- R5: From the acceptance of the last word until the final digest word, in_ready stays 0. in_valid and in_word are ignored in that window and have no effect on the digest.
- R6: After the final digest word the state, the feedback word and the round count return to their reset values. A repeated message therefore yields the same digest.
- R7: The round count advances by one on every small round, whatever the phase, and wraps modulo 2^W. All-ones message words and multi-word messages produce the model digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Message word offered |
| in_last | input | 1 | Offered word is the final message word |
| in_word | input | W | Message word |
| in_ready | output | 1 | Core takes a word this cycle if in_valid is 1 |
| out_valid | output | 1 | Digest word present (one-cycle pulse) |
| out_last | output | 1 | Present digest word is the final one |
| out_word | output | W | Digest word |

## Verification
Cycles are counted from the edge that takes a word. in_ready falls right after that edge and must come back after edge 7. After the last word, digest word k is due just after edge 143 + 8k, and in_ready returns after edge 199. The bench counts edges from the acceptance edge and samples on the falling clock edge between rising edges. In every cycle it compares out_valid with the exact due cycle, so an early, late or doubled pulse is reported. A fixed-position data comparison is not enough on its own to catch these.

// File: rtl/whash_pkg.sv
package whash_pkg;

  // Phase of the hash engine
  typedef enum logic [1:0] {
    PH_ABSORB = 2'd0,
    PH_BLANK  = 2'd1,
    PH_EMIT   = 2'd2
  } phase_e;

  // Small rounds per full round
  localparam int unsigned STEPS_PER_ROUND = 8;

endpackage

// File: rtl/whash_step.sv
// One small round computed on fixed taps of the shifted state.
module whash_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] tap_prev,  // x[r-1]
  input  logic [W-1:0] tap_cur,   // x[r]
  input  logic [W-1:0] tap_next,  // x[r+1]
  input  logic [W-1:0] tap_far,   // x[H/2+r]
  input  logic [W-1:0] acc,       // feedback word
  input  logic [W-1:0] cnt,       // round count
  input  logic [W-1:0] din,       // input word
  output logic [W-1:0] cur_new,
  output logic [W-1:0] acc_new
);

  localparam int unsigned ROT = W / 4;

  logic [W-1:0] mix;
  logic [W-1:0] rot;
  logic [W-1:0] fval;

  always_comb begin
    mix     = {tap_prev[W-2:0], 1'b0} ^ tap_next ^ acc ^ cnt;
    rot     = (mix >> ROT) | (mix << (W - ROT));
    fval    = rot + (rot << 3);
    cur_new = tap_cur ^ fval;
    acc_new = acc ^ fval ^ din ^ tap_far;
  end

endmodule

// File: rtl/whash_state.sv
// State words held in shifted order: slot k holds x[(r-1+k) mod H].
module whash_state #(
  parameter int unsigned W = 32,
  parameter int unsigned H = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  input  logic [W-1:0] new_cur,
  input  logic [W-1:0] new_acc,
  output logic [W-1:0] tap_prev,
  output logic [W-1:0] tap_cur,
  output logic [W-1:0] tap_next,
  output logic [W-1:0] tap_far,
  output logic [W-1:0] acc,
  output logic [W-1:0] cnt
);

  localparam int unsigned FAR = H / 2 + 1;

  logic [H-1:0][W-1:0] sh_q, sh_d, sh_shift;
  logic [W-1:0]        acc_q, acc_d;
  logic [W-1:0]        cnt_q, cnt_d;

  // Shifted image after one small round
  for (genvar k = 0; k < H; k++) begin : g_sh
    if (k == 0) begin : g_first
      assign sh_shift[k] = new_cur;
    end else if (k == H - 1) begin : g_wrap
      assign sh_shift[k] = sh_q[0];
    end else begin : g_mid
      assign sh_shift[k] = sh_q[k+1];
    end
  end

  always_comb begin
    sh_d  = sh_q;
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clr) begin
      sh_d  = '0;
      acc_d = '0;
      cnt_d = W'(1);
    end else if (adv) begin
      sh_d  = sh_shift;
      acc_d = new_acc;
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      acc_q <= '0;
      cnt_q <= W'(1);
    end else if (adv || clr) begin
      sh_q  <= sh_d;
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign tap_prev = sh_q[0];
  assign tap_cur  = sh_q[1];
  assign tap_next = sh_q[2];
  assign tap_far  = sh_q[FAR];
  assign acc      = acc_q;
  assign cnt      = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (cnt_q == $past(cnt_q) + W'(1))) else $error("count step"); // R7

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt_q) && $stable(acc_q)) else $error("idle hold"); // R2

endmodule

// File: rtl/whash_ctrl.sv
// Phase sequencing, small-round counting and input/output handshake.
module whash_ctrl
  import whash_pkg::*;
#(
  parameter int unsigned H = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic take,
  output logic adv,
  output logic zero_in,
  output logic emit_now,
  output logic clr,
  output logic out_valid,
  output logic out_last
);

  localparam int unsigned SUB   = STEPS_PER_ROUND;
  localparam int unsigned SUB_W = $clog2(SUB);
  localparam int unsigned HALF  = H / 2;
  localparam int unsigned RW    = $clog2(H);

  phase_e            phase_q, phase_d;
  logic              busy_q, busy_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [RW-1:0]     rnd_q, rnd_d;
  logic              last_q, last_d;
  logic              ov_q, ol_q;
  logic              rend;

  always_comb begin
    in_ready = (phase_q == PH_ABSORB) && !busy_q;
    take     = in_valid && in_ready;
    adv      = take || busy_q;
    zero_in  = (phase_q != PH_ABSORB);
    rend     = adv && (sub_q == SUB_W'(SUB - 1));
    emit_now = rend && (phase_q == PH_EMIT);
    clr      = emit_now && (rnd_q == RW'(HALF - 1));
  end

  always_comb begin
    phase_d = phase_q;
    busy_d  = busy_q;
    rnd_d   = rnd_q;
    last_d  = last_q;
    sub_d   = sub_q;
    if (adv) begin
      sub_d = rend ? '0 : sub_q + SUB_W'(1);
    end
    if (take) begin
      busy_d = 1'b1;
      last_d = in_last;
    end
    if (rend) begin
      unique case (phase_q)
        PH_ABSORB: begin
          if (last_q) begin
            phase_d = PH_BLANK;
            rnd_d   = '0;
          end else begin
            busy_d = 1'b0;
          end
        end
        PH_BLANK: begin
          if (rnd_q == RW'(H - 1)) begin
            phase_d = PH_EMIT;
            rnd_d   = '0;
          end else begin
            rnd_d = rnd_q + RW'(1);
          end
        end
        PH_EMIT: begin
          if (rnd_q == RW'(HALF - 1)) begin
            phase_d = PH_ABSORB;
            busy_d  = 1'b0;
            last_d  = 1'b0;
            rnd_d   = '0;
          end else begin
            rnd_d = rnd_q + RW'(1);
          end
        end
        default: phase_d = PH_ABSORB;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ABSORB;
      busy_q  <= 1'b0;
      sub_q   <= '0;
      rnd_q   <= '0;
      last_q  <= 1'b0;
    end else if (adv) begin
      phase_q <= phase_d;
      busy_q  <= busy_d;
      sub_q   <= sub_d;
      rnd_q   <= rnd_d;
      last_q  <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
    end else begin
      ov_q <= emit_now;
      ol_q <= clr;
    end
  end

  assign out_valid = ov_q;
  assign out_last  = ol_q;

  AST_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready) else $error("ready after take"); // R2

  AST_EMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |=> !ov_q) else $error("emit pulse length"); // R4

  AST_QUIET_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !ol_q) |-> !in_ready) else $error("ready during output"); // R5

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ol_q |-> ov_q) else $error("last without valid"); // R4

endmodule

// File: rtl/whash_core.sv
module whash_core #(
  parameter int unsigned W = 32,
  parameter int unsigned H = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_last,
  input  logic [W-1:0] in_word,
  output logic         in_ready,
  output logic         out_valid,
  output logic         out_last,
  output logic [W-1:0] out_word
);

  // Reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rsync_q[1];

  logic         take, adv, zero_in, emit_now, clr;
  logic [W-1:0] hold_q, hold_d;
  logic [W-1:0] din;
  logic [W-1:0] dig_q, dig_d;
  logic [W-1:0] tap_prev, tap_cur, tap_next, tap_far, acc, cnt;
  logic [W-1:0] cur_new, acc_new;

  whash_ctrl #(.H(H)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .take     (take),
    .adv      (adv),
    .zero_in  (zero_in),
    .emit_now (emit_now),
    .clr      (clr),
    .out_valid(out_valid),
    .out_last (out_last)
  );

  // Word under absorption: live on the taking edge, held afterwards
  always_comb begin
    hold_d = take ? in_word : hold_q;
    if (take) begin
      din = in_word;
    end else if (zero_in) begin
      din = '0;
    end else begin
      din = hold_q;
    end
    dig_d = emit_now ? acc_new : dig_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      hold_q <= '0;
    end else if (take) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dig_q <= '0;
    end else if (emit_now) begin
      dig_q <= dig_d;
    end
  end

  whash_step #(.W(W)) u_step (
    .tap_prev(tap_prev),
    .tap_cur (tap_cur),
    .tap_next(tap_next),
    .tap_far (tap_far),
    .acc     (acc),
    .cnt     (cnt),
    .din     (din),
    .cur_new (cur_new),
    .acc_new (acc_new)
  );

  whash_state #(.W(W), .H(H)) u_state (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .adv     (adv),
    .clr     (clr),
    .new_cur (cur_new),
    .new_acc (acc_new),
    .tap_prev(tap_prev),
    .tap_cur (tap_cur),
    .tap_next(tap_next),
    .tap_far (tap_far),
    .acc     (acc),
    .cnt     (cnt)
  );

  assign out_word = dig_q;

  AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_last |-> (cnt == W'(1) && acc == '0 && in_ready)) else $error("restart state"); // R6

  AST_NO_TAKE_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_s_n)
    emit_now |-> !take) else $error("take during emit"); // R5

endmodule

// File: tb/sim_whash_core.sv
`timescale 1ns/1ps
module sim_whash_core;

  localparam int unsigned W = 32;
  localparam int unsigned H = 16;
  localparam int unsigned HALF = H / 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_last;
  logic [W-1:0] in_word;
  logic         in_ready, out_valid, out_last;
  logic [W-1:0] out_word;

  always #2 clk = ~clk;

  whash_core #(.W(W), .H(H)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_word(in_word), .in_ready(in_ready), .out_valid(out_valid),
    .out_last(out_last), .out_word(out_word)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // Index-based reference model (no shifting)
  logic [W-1:0] mx [H];
  logic [W-1:0] md, mr;
  logic [W-1:0] exp_dig [HALF];
  logic [W-1:0] got_dig [HALF];
  logic [W-1:0] first_dig [HALF];

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_clear();
    for (int i = 0; i < H; i++) mx[i] = '0;
    md = '0;
    mr = W'(1);
  endtask

  task automatic ref_small(input logic [W-1:0] p);
    logic [W-1:0] v, rt, f;
    int ip, ic, inx, ifr;
    ic  = int'(mr % H);
    ip  = (ic + H - 1) % H;
    inx = (ic + 1) % H;
    ifr = (ic + HALF) % H;
    v   = (mx[ip] << 1) ^ mx[inx] ^ md ^ mr;
    rt  = (v >> (W/4)) | (v << (W - W/4));
    f   = rt * W'(9);
    mx[ic] = mx[ic] ^ f;
    md  = md ^ f ^ p ^ mx[ifr];
    mr  = mr + W'(1);
  endtask

  task automatic ref_round(input logic [W-1:0] p);
    for (int s = 0; s < 8; s++) ref_small(p);
  endtask

  // Send a message and check timing and digest (R2, R3, R4, R5)
  task automatic send_msg(input logic [W-1:0] words [8], input int n, input bit poke);
    int k;
    ref_clear();
    for (int i = 0; i < n; i++) ref_round(words[i]);
    for (int i = 0; i < H; i++) ref_round('0);
    for (int i = 0; i < HALF; i++) begin
      ref_round('0);
      exp_dig[i] = md;
    end
    for (int i = 0; i < n; i++) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_word  = words[i];
      in_last  = (i == n - 1);
      @(posedge clk);
      if (i != n - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 ready low after take", W'(in_ready), W'(0));
        repeat (6) begin
          @(negedge clk);
          chk("R2 ready held low", W'(in_ready), W'(0));
        end
        @(negedge clk);
        chk("R2 ready back after 8", W'(in_ready), W'(1));
      end
    end
    k = 0;
    for (int e = 0; e <= 206; e++) begin
      @(negedge clk);
      if (poke && e >= 2 && e <= 150) begin
        in_valid = 1'b1;
        in_word  = W'(32'hDEAD_0000) ^ W'(e);
        in_last  = e[0];
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      if (e >= 143 && e <= 199 && ((e - 143) % 8) == 0) begin
        chk("R4 valid due", W'(out_valid), W'(1));
        chk("R4 last flag", W'(out_last), W'(k == HALF - 1));
        if (k < HALF) begin
          got_dig[k] = out_word;
          chk("R3 digest word", out_word, exp_dig[k]);
        end
        k++;
      end else begin
        chk("R4 no stray valid", W'(out_valid), W'(0));
      end
      if (e == 0 || e == 60 || e == 142 || e == 198)
        chk("R5 ready low until end", W'(in_ready), W'(0));
      if (e == 199)
        chk("R6 ready after final", W'(in_ready), W'(1));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    in_valid = 1'b0; in_last = 1'b0; in_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", W'(in_ready), W'(1));
    chk("R1 no valid after reset", W'(out_valid), W'(0));
    chk("R1 last low after reset", W'(out_last), W'(0));
  endtask

  task automatic t_single();
    logic [W-1:0] m [8];
    for (int i = 0; i < 8; i++) m[i] = '0;
    m[0] = 32'h0000_0000;
    send_msg(m, 1, 1'b0);
    for (int i = 0; i < HALF; i++) first_dig[i] = got_dig[i];
  endtask

  task automatic t_multi();
    logic [W-1:0] m [8];
    m[0] = 32'hFFFF_FFFF; m[1] = 32'h8000_0001; m[2] = 32'h0123_4567;
    m[3] = 32'hFFFF_FFFF; m[4] = 32'hA5A5_5A5A; m[5] = '0; m[6] = '0; m[7] = '0;
    send_msg(m, 5, 1'b0); // R7 wrap arithmetic, R3
  endtask

  task automatic t_busy_ignore();
    logic [W-1:0] m [8];
    for (int i = 0; i < 8; i++) m[i] = W'(32'h1111_1111 * (i + 1));
    send_msg(m, 2, 1'b1); // R5 input ignored while busy
  endtask

  task automatic t_repeat();
    logic [W-1:0] m [8];
    for (int i = 0; i < 8; i++) m[i] = '0;
    send_msg(m, 1, 1'b0);
    for (int i = 0; i < HALF; i++)
      chk("R6 repeat digest equal", got_dig[i], first_dig[i]);
  endtask

  task automatic t_long();
    logic [W-1:0] m [8];
    for (int i = 0; i < 8; i++) m[i] = W'(32'h9E37_79B9) ^ W'(i << 5);
    send_msg(m, 8, 1'b0); // R7 count across many words, R3
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=below 100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_busy_ignore();
    t_repeat();
    t_long();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule